// File: doc/BRIEF.md
# Signed Two's-Complement Sequential Multiplier

This block multiplies two signed 4-bit operands, one step per clock cycle, and returns a signed 8-bit product. It does not convert negative operands to magnitudes. The accumulator keeps the sign of the partial product through an arithmetic right shift. The adder result is written one bit position to the right, so one clock cycle both adds the multiplicand and shifts.

A one-cycle `start` pulse, given while the block is idle, captures both operands. The block then runs one step per multiplier bit. Bits that are 0 only shift. Bits that are 1 add the multiplicand and shift in the same cycle. The multiplier's top bit carries weight −2^(W−1), so when that bit is set the last step subtracts the multiplicand instead of adding it. `done` pulses once when the product is ready. The product then stays on the output until the next accepted start.

Top module: `sgn_seq_mult`

## Requirements
- R1: For every pair of 4-bit two's-complement operands, `product` equals their signed product as an 8-bit two's-complement value.
- R2: All four sign combinations are correct: 0111×0101 = 0x23, 1101×0101 = 0xF1, 0101×1101 = 0xF1, 1011×1101 = 0x0F.
- R3: The most negative operand is handled without overflow. 1000×1000 gives 0x40 (+64), and 1000×0111 and 0111×1000 give 0xC8 (−56).
- R4: `start` is sampled high at clock edge E0 while idle. `done` is then high only in the cycle that follows edge E4, and it is low in the cycles before and after that one.
- R5: After `done`, `product` keeps its value until the next accepted start.
- R6: `start` is ignored while an operation is in progress. The result of the running operation is unchanged, and no extra `done` pulse follows.
- R7: Reset is synchronous and active low. On the edge where `rst_n` is low, `done` and `product` go to 0 and the block goes idle. An operation cut off by reset never raises `done`.
- R8: A start given in the same cycle that `done` is high is accepted, and the new operation completes with its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse; captures the operands when the block is idle |
| mcand | input | 4 | Multiplicand, two's complement |
| mplier | input | 4 | Multiplier, two's complement |
| product | output | 8 | Signed product; held after completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step count or a stuck controller state shows at the ports within five cycles of a start: `done` comes early, comes late, comes twice, or never comes. A wrong shift or a wrong adder operation shows only in the final product, as soon as `done` rises. The errors depend on the operand pattern. Sign-extension faults appear only with negative partial products. A missed final-step subtraction appears only when the multiplier is negative. The operands are therefore swept over the whole operand space, and the −8 operands are checked directly, because they alone reach the adder's full range.

// File: rtl/ssm_pkg.sv
// Package: shared types for the signed sequential multiplier.
// Assumes: nothing beyond standard SystemVerilog.
package ssm_pkg;

    // Controller states: waiting for start, or stepping through multiplier bits
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ssm_state_e;

endpackage

// File: rtl/ssm_ctrl.sv
// Module: ssm_ctrl
// Sequences one operation. It accepts start only while idle, runs WIDTH step
// cycles, flags the final step so the datapath can subtract, and registers a
// one-cycle done pulse after that step.
// Assumes: WIDTH >= 2; start is sampled on the rising edge.
module ssm_ctrl #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    import ssm_pkg::*;

    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    ssm_state_e    state_q;
    logic [CW-1:0] cnt_q;

    // Decode the step strobes from the state and the step counter
    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        last = step && (cnt_q == LAST_IDX);
        busy = step;
    end

    // Advance the state, count the steps, and register the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= last;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (last) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ssm_step_unit.sv
// Module: ssm_step_unit
// Combinational logic for one multiplier step. If the current multiplier bit
// is 0, it shifts {hi,lo} right arithmetically. If the bit is 1, it adds the
// multiplicand to the sign-extended upper half, or subtracts it on the final
// step, and writes the (WIDTH+1)-bit sum one position to the right. One cycle
// therefore both adds and shifts.
// Assumes: hi, lo and mc are two's complement; a (WIDTH+1)-bit sum never
// overflows, so its top bit is the true sign.
module ssm_step_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] hi,
    input  logic [WIDTH-1:0] lo,
    input  logic [WIDTH-1:0] mc,
    input  logic             last,
    output logic [WIDTH-1:0] hi_nxt,
    output logic [WIDTH-1:0] lo_nxt
);
    localparam int EW = WIDTH + 1;

    logic [EW-1:0] hi_ext;
    logic [EW-1:0] mc_ext;
    logic [EW-1:0] sum;

    // Sign-extend both addends and form the sum or difference
    always_comb begin
        hi_ext = {hi[WIDTH-1], hi};
        mc_ext = {mc[WIDTH-1], mc};
        sum    = last ? (hi_ext - mc_ext) : (hi_ext + mc_ext);
    end

    // Choose between the plain arithmetic shift and the shifted sum
    always_comb begin
        if (lo[0]) begin
            hi_nxt = sum[EW-1:1];
            lo_nxt = {sum[0], lo[WIDTH-1:1]};
        end else begin
            hi_nxt = {hi[WIDTH-1], hi[WIDTH-1:1]};
            lo_nxt = {hi[0], lo[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/ssm_acc.sv
// Module: ssm_acc
// Holds the multiplicand and the accumulator. The accumulator's upper half is
// the partial product. Its lower half starts as the multiplier and fills with
// product bits as the steps run. Load clears the upper half and captures both
// operands. Each step writes the values from the step unit.
// Assumes: load and step are never high together.
module ssm_acc #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    input  logic [WIDTH-1:0] hi_nxt,
    input  logic [WIDTH-1:0] lo_nxt,
    output logic [WIDTH-1:0] hi_q,
    output logic [WIDTH-1:0] lo_q,
    output logic [WIDTH-1:0] mc_q
);
    // Capture operands on load; write the step result on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            mc_q <= '0;
        end else if (load) begin
            hi_q <= '0;
            lo_q <= mplier;
            mc_q <= mcand;
        end else if (step) begin
            hi_q <= hi_nxt;
            lo_q <= lo_nxt;
        end
    end
endmodule

// File: rtl/sgn_seq_mult.sv
// Module: sgn_seq_mult
// Top level of the signed sequential multiplier: the controller, the
// accumulator registers and the step unit. The product is the concatenated
// accumulator, valid from done onward.
// Assumes: WIDTH >= 2; start is a synchronous pulse.
module sgn_seq_mult #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product,
    output logic               done
);
    logic             load;
    logic             step;
    logic             last;
    logic             busy;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic [WIDTH-1:0] mc_q;
    logic [WIDTH-1:0] hi_nxt;
    logic [WIDTH-1:0] lo_nxt;

    ssm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    ssm_acc #(.WIDTH(WIDTH)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .mcand  (mcand),
        .mplier (mplier),
        .hi_nxt (hi_nxt),
        .lo_nxt (lo_nxt),
        .hi_q   (hi_q),
        .lo_q   (lo_q),
        .mc_q   (mc_q)
    );

    ssm_step_unit #(.WIDTH(WIDTH)) u_step (
        .hi     (hi_q),
        .lo     (lo_q),
        .mc     (mc_q),
        .last   (last),
        .hi_nxt (hi_nxt),
        .lo_nxt (lo_nxt)
    );

    // The product is the upper and lower accumulator halves side by side
    always_comb product = {hi_q, lo_q};
endmodule

// File: rtl/ssm_checker.sv
// Module: ssm_checker
// Assertions for sgn_seq_mult, attached with bind. A small reference register
// holds the signed product of the captured operands. A run-length counter
// checks the step count without deep $past.
// Assumes: bound into sgn_seq_mult, with the internal busy, last and mc_q.
module ssm_checker #(
    parameter int WIDTH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               last,
    input logic               done,
    input logic [WIDTH-1:0]   mcand,
    input logic [WIDTH-1:0]   mplier,
    input logic [WIDTH-1:0]   mc_q,
    input logic [2*WIDTH-1:0] product
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] ref_q;
    logic          ref_v;
    logic [7:0]    run_len;
    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;

    // Sign-extend the operands for the reference product
    always_comb begin
        a_ext = {{WIDTH{mcand[WIDTH-1]}}, mcand};
        b_ext = {{WIDTH{mplier[WIDTH-1]}}, mplier};
    end

    // Record the expected product at each accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            ref_v <= 1'b0;
        end else if (start && !busy) begin
            ref_q <= PW'(a_ext * b_ext);
            ref_v <= 1'b1;
        end
    end

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else run_len <= '0;
    end

    p_product_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ref_v && product == ref_q));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_step_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == 8'(WIDTH)));

    p_hold_product_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && $stable(mc_q)));

    p_reset_idle_r7: assert property (@(posedge clk)
        !rst_n |=> (!done && !busy));
endmodule

bind sgn_seq_mult ssm_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .last    (last),
    .done    (done),
    .mcand   (mcand),
    .mplier  (mplier),
    .mc_q    (mc_q),
    .product (product)
);

// File: tb/sgn_seq_mult_test.sv
`timescale 1ns/1ps
module sgn_seq_mult_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] mcand = '0;
    logic [3:0] mplier = '0;
    logic [7:0] product;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;

    // {mcand, mplier, expected product}
    localparam logic [15:0] VEC [12] = '{
        16'h7523, 16'hD5F1, 16'h5DF1, 16'hBD0F,
        16'h8840, 16'h87C8, 16'h78C8, 16'hFF01,
        16'h0800, 16'h81F8, 16'h7731, 16'h1FFF
    };

    sgn_seq_mult uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product),
        .done    (done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] smul(input logic [3:0] a, input logic [3:0] b);
        logic [7:0] ea = {{4{a[3]}}, a};
        logic [7:0] eb = {{4{b[3]}}, b};
        return 8'(ea * eb);
    endfunction

    // Starts at a negedge; returns at the negedge after done should have gone low
    task automatic run_op(input logic [3:0] a, input logic [3:0] b,
                          input logic [7:0] exp, input string req);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R4 early done", {7'd0, done}, 8'd0);
        @(negedge clk);
        chk(done == 1'b1, "R4 done", {7'd0, done}, 8'd1);
        chk(product == exp, req, product, exp);
        @(negedge clk);
        chk(done == 1'b0, "R4 done width", {7'd0, done}, 8'd0);
        chk(product == exp, "R5 hold", product, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(done == 1'b0, "R7 reset done", {7'd0, done}, 8'd0);
        chk(product == 8'h00, "R7 reset product", product, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // Table: R2 sign cases, R3 extreme operands, R1 others
        for (int i = 0; i < 12; i++) begin
            string tag;
            tag = (i < 4) ? "R2" : (i < 7) ? "R3" : "R1";
            run_op(VEC[i][15:12], VEC[i][11:8], VEC[i][7:0], tag);
        end

        // R1: full operand sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_op(4'(a), 4'(b), smul(4'(a), 4'(b)), "R1 sweep");
            end
        end

        // R6: start with other operands while busy is ignored
        mcand = 4'h3; mplier = 4'hE; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        mcand = 4'h7; mplier = 4'h7; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R6 early done", {7'd0, done}, 8'd0);
        @(negedge clk);
        chk(done == 1'b1, "R6 done", {7'd0, done}, 8'd1);
        chk(product == 8'hFA, "R6 product", product, 8'hFA);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R6 extra done", {7'd0, done}, 8'd0);
        end
        chk(product == 8'hFA, "R5 hold long", product, 8'hFA);

        // R8: back-to-back start in the done cycle
        mcand = 4'h6; mplier = 4'h3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R8 first done", {7'd0, done}, 8'd1);
        chk(product == 8'h12, "R8 first product", product, 8'h12);
        mcand = 4'hA; mplier = 4'h5; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R8 second done", {7'd0, done}, 8'd1);
        chk(product == 8'hE2, "R8 second product", product, 8'hE2);
        @(negedge clk);

        // R7: reset in mid-operation aborts without done
        mcand = 4'h5; mplier = 4'h5; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7 abort done", {7'd0, done}, 8'd0);
        chk(product == 8'h00, "R7 abort product", product, 8'h00);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R7 no done after abort", {7'd0, done}, 8'd0);
        end
        run_op(4'h9, 4'h9, 8'h31, "R7 recovery");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule